// File: doc/BRIEF.md
# Reset cause capture controller

This block merges a set of reset requests into a single system reset output and keeps a record of which request was the root cause of it. The requests are power-on, an external reset pin, brown-out detection on three supply rails, loss of a system clock, and two software requests (cold reset and warm reset) made through a 32-bit control/status register. Brown-out and clock-loss events are gated by enable bits in that register. The analog detectors, boot-code flags and wakeup flags are outside the block. They arrive as plain input bits, and the four flag bits are only mirrored into the register.

The cause field is captured once, from the first request seen while capture is armed. It then stays frozen. A slow tick from the low-frequency domain drives the re-arm. Once every request has gone away, one tick opens a copy window and the next tick closes it and re-arms capture. Any request that lands inside the copy window is recorded as power-on, whatever its real source. The system reset output stays high while any enabled request is active and for a fixed number of cycles after the last one drops.

Top module: `rstcause_ctl`

## Requirements
- R1: After the block's own reset, `rd_data` reads 0x000001C0, the cause field is 0 and `sys_rst` is low.
- R2: Register layout: bits 8, 7, 6 and 5 are read/write enables for VDDS brown-out, VDDR brown-out, VDD brown-out and clock loss. Bits 15:12 mirror `ext_flags[3:0]`. Bits 3:1 hold the read-only cause field. Every other bit, including the request bits 31 and 4, reads as 0, and writes to those bits are ignored.
- R3: Cause codes are 0 power-on, 1 pin, 2 VDDS brown-out, 4 VDDR brown-out, 5 clock loss, 6 software cold reset, 7 software warm reset. Code 3 never appears.
- R4: A brown-out or clock-loss input whose enable bit is 0 raises no reset and leaves the cause field unchanged.
- R5: A write with bit 31 set raises `sys_rst` in the following cycle and is recorded as code 6. A write with bit 4 set does the same and is recorded as code 7. A write with both bits clear raises no reset.
- R6: The cause recorded is the first request seen while armed. When requests arrive in the same cycle, the one recorded is the first in this order: power-on, pin, VDDS, VDDR, clock loss, cold, warm.
- R7: Once a cause is captured, later or overlapping requests do not change it until capture has re-armed.
- R8: Capture re-arms only after all requests have released, a `slow_tick` has opened the copy window, and a second `slow_tick` has closed it. A tick seen while any request is active does not count.
- R9: A request that arrives inside the copy window is recorded as code 0.
- R10: `sys_rst` is high in every cycle in which an enabled request is active, and it stays high for HOLD_CYC (2) more cycles after the last request drops.
- R11: An enabled VDD brown-out raises a system reset and is recorded as code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| por_req | input | 1 | Power-on reset request |
| pin_req | input | 1 | External reset pin request |
| bod_vdds | input | 1 | VDDS brown-out detected |
| bod_vddr | input | 1 | VDDR brown-out detected |
| bod_vdd | input | 1 | VDD brown-out detected |
| clk_loss | input | 1 | Clock loss detected |
| slow_tick | input | 1 | One-cycle pulse per low-frequency period |
| ext_flags | input | 4 | Wakeup and boot flags mirrored into bits 15:12 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| sys_rst | output | 1 | Combined system reset |

## Verification
On every cycle the assertions check four things. Code 3 never shows. The bits that always read zero stay zero. The cause field changes only in a cycle that follows an active request. `sys_rst` stays high through the hold tail, and it follows a cold-reset write. Which source wins a tie, the gating by the enable bits, the frozen cause across overlapping requests, and the two-tick re-arm with its power-on substitution inside the copy window all depend on ordered sequences of stimulus. Only the directed scenarios in the bench show these.

// File: rtl/rstcause_ctl.sv
module rstcause_ctl #(
  parameter int HOLD_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_req,
  input  logic        pin_req,
  input  logic        bod_vdds,
  input  logic        bod_vddr,
  input  logic        bod_vdd,
  input  logic        clk_loss,
  input  logic        slow_tick,
  input  logic [3:0]  ext_flags,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        sys_rst
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC);

  typedef enum logic [1:0] {ST_ARMED, ST_HELD, ST_COPY} cap_st_t;

  cap_st_t          st_q;
  logic [3:0]       en_q;      // {vdds, vddr, vdd, clk}
  logic [2:0]       cause_q;
  logic             cold_q, warm_q;
  logic [CNT_W-1:0] tail_q;
  logic [6:0]       src;
  logic             any_src;
  logic [2:0]       root;
  logic             unused_wr;

  assign src[0] = por_req | (bod_vdd & en_q[1]);
  assign src[1] = pin_req;
  assign src[2] = bod_vdds & en_q[3];
  assign src[3] = bod_vddr & en_q[2];
  assign src[4] = clk_loss & en_q[0];
  assign src[5] = cold_q;
  assign src[6] = warm_q;
  assign any_src = |src;

  always_comb begin
    if      (src[0]) root = 3'd0;
    else if (src[1]) root = 3'd1;
    else if (src[2]) root = 3'd2;
    else if (src[3]) root = 3'd4;
    else if (src[4]) root = 3'd5;
    else if (src[5]) root = 3'd6;
    else             root = 3'd7;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 4'b1110;
      cold_q <= 1'b0;
      warm_q <= 1'b0;
    end else begin
      cold_q <= wr_en & wr_data[31];
      warm_q <= wr_en & wr_data[4];
      if (wr_en) en_q <= wr_data[8:5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ARMED;
      cause_q <= 3'd0;
    end else begin
      case (st_q)
        ST_ARMED: if (any_src) begin
          cause_q <= root;
          st_q    <= ST_HELD;
        end
        ST_HELD: if (!any_src && slow_tick) st_q <= ST_COPY;
        ST_COPY: if (any_src) begin
          cause_q <= 3'd0;
          st_q    <= ST_HELD;
        end else if (slow_tick) begin
          st_q <= ST_ARMED;
        end
        default: st_q <= ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tail_q <= '0;
    else if (any_src)        tail_q <= HOLD_LD;
    else if (tail_q != '0)   tail_q <= tail_q - 1'b1;
  end

  assign sys_rst   = any_src | (tail_q != '0);
  assign rd_data   = {16'd0, ext_flags, 3'd0, en_q, 1'b0, cause_q, 1'b0};
  assign unused_wr = ^{wr_data[30:9], wr_data[3:0]};

endmodule

module rstcause_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sys_rst,
  input logic        any_src,
  input logic        wr_en,
  input logic        wr_cold,
  input logic [31:0] rd_data
);
  localparam logic [31:0] ZERO_MASK = 32'hFFFF_0E11;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r3_no_code3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    rd_data[3:1] != 3'd3);

  a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (rd_data & ZERO_MASK) == 32'd0);

  a_r7_cause_moves_on_req: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    !$stable(rd_data[3:1]) |-> $past(any_src));

  a_r10_hold_tail: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    ($past(any_src) && !any_src) |-> sys_rst);

  a_r5_cold_raises: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (wr_en && wr_cold) |=> sys_rst);
endmodule

bind rstcause_ctl rstcause_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .any_src(any_src),
  .wr_en(wr_en), .wr_cold(wr_data[31]), .rd_data(rd_data)
);

// File: tb/rstcause_ctl_bench.sv
module rstcause_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic por_req = 0, pin_req = 0, bod_vdds = 0, bod_vddr = 0, bod_vdd = 0, clk_loss = 0;
  logic slow_tick = 0, wr_en = 0;
  logic [3:0]  ext_flags = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        sys_rst;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rstcause_ctl u_rstcause_ctl (
    .clk(clk), .rst_n(rst_n), .por_req(por_req), .pin_req(pin_req),
    .bod_vdds(bod_vdds), .bod_vddr(bod_vddr), .bod_vdd(bod_vdd), .clk_loss(clk_loss),
    .slow_tick(slow_tick), .ext_flags(ext_flags), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sys_rst(sys_rst));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    #0;
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic release_all();
    por_req = 0; pin_req = 0; bod_vdds = 0; bod_vddr = 0; bod_vdd = 0; clk_loss = 0;
  endtask

  task automatic reg_write(logic [31:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = 0;
  endtask

  task automatic tick();
    slow_tick = 1; step(); slow_tick = 0;
  endtask

  task automatic rearm();
    release_all();
    repeat (4) step();
    tick(); step(); step(); tick(); step();
  endtask

  task automatic t_reset();
    chk("R1 reset value", rd_data, 32'h1C0);
    chk("R1 sys_rst low", {31'd0, sys_rst}, 0);
  endtask

  task automatic t_layout();
    reg_write(32'h7FFF_FFEF); step();
    chk("R2 writable enables only", rd_data, 32'h1E0);
    chk("R5 no request bits, no reset", {31'd0, sys_rst}, 0);
    ext_flags = 4'hA; step();
    chk("R2 flags mirrored in 15:12", rd_data, 32'hA1E0);
    ext_flags = 0;
    reg_write(32'h1C0); step();
    chk("R2 enables rewritten", rd_data, 32'h1C0);
  endtask

  task automatic t_pin_tail();
    pin_req = 1; #1;
    chk("R10 sys_rst with pin", {31'd0, sys_rst}, 1);
    step(); step();
    chk("R3 pin code 1", {29'd0, rd_data[3:1]}, 1);
    pin_req = 0; #1;
    chk("R10 tail cycle 1", {31'd0, sys_rst}, 1);
    step();
    chk("R10 tail cycle 2", {31'd0, sys_rst}, 1);
    step();
    chk("R10 released after tail", {31'd0, sys_rst}, 0);
    rearm();
  endtask

  task automatic t_gating();
    clk_loss = 1; step(); step();
    chk("R4 disabled clock loss no reset", {31'd0, sys_rst}, 0);
    chk("R4 cause unchanged", {29'd0, rd_data[3:1]}, 1);
    clk_loss = 0;
    reg_write(32'h1E0);
    clk_loss = 1; step();
    chk("R3 clock loss code 5", {29'd0, rd_data[3:1]}, 5);
    rearm();
    bod_vdds = 1; step();
    chk("R3 VDDS code 2", {29'd0, rd_data[3:1]}, 2);
    rearm();
    bod_vddr = 1; step();
    chk("R3 VDDR code 4", {29'd0, rd_data[3:1]}, 4);
    rearm();
    reg_write(32'h160);
    bod_vddr = 1; step(); step();
    chk("R4 disabled VDDR no reset", {31'd0, sys_rst}, 0);
    chk("R4 disabled VDDR cause kept", {29'd0, rd_data[3:1]}, 4);
    bod_vddr = 0;
    reg_write(32'h1E0);
    bod_vdd = 1; #1;
    chk("R11 VDD brown-out resets", {31'd0, sys_rst}, 1);
    step();
    chk("R11 VDD recorded as 0", {29'd0, rd_data[3:1]}, 0);
    rearm();
  endtask

  task automatic t_ties();
    pin_req = 1; bod_vdds = 1; step();
    chk("R6 pin beats VDDS", {29'd0, rd_data[3:1]}, 1);
    rearm();
    bod_vdds = 1; clk_loss = 1; step();
    chk("R6 VDDS beats clock loss", {29'd0, rd_data[3:1]}, 2);
    rearm();
    bod_vddr = 1; step(); pin_req = 1; step(); por_req = 1; step();
    chk("R7 first source kept", {29'd0, rd_data[3:1]}, 4);
    rearm();
  endtask

  task automatic t_software();
    reg_write(32'h8000_01E0); #1;
    chk("R5 cold raises sys_rst", {31'd0, sys_rst}, 1);
    step();
    chk("R5 cold code 6", {29'd0, rd_data[3:1]}, 6);
    chk("R2 bit 31 reads 0", {31'd0, rd_data[31]}, 0);
    rearm();
    reg_write(32'h1F0); #1;
    chk("R5 warm raises sys_rst", {31'd0, sys_rst}, 1);
    step();
    chk("R5 warm code 7", {29'd0, rd_data[3:1]}, 7);
    repeat (4) step();
    pin_req = 1; step();
    chk("R8 no rearm without tick", {29'd0, rd_data[3:1]}, 7);
    tick(); pin_req = 0; step(); step();
    pin_req = 1; step();
    chk("R8 tick while active ignored", {29'd0, rd_data[3:1]}, 7);
    rearm();
    pin_req = 1; step();
    chk("R8 rearmed after two ticks", {29'd0, rd_data[3:1]}, 1);
  endtask

  task automatic t_window();
    release_all(); repeat (4) step();
    tick();
    bod_vdds = 1; step();
    chk("R9 window source recorded 0", {29'd0, rd_data[3:1]}, 0);
    chk("R9 window source resets", {31'd0, sys_rst}, 1);
    rearm();
    bod_vdds = 1; step();
    chk("R9 after window real code", {29'd0, rd_data[3:1]}, 2);
    rearm();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_layout();
    t_pin_tail();
    t_gating();
    t_ties();
    t_software();
    t_window();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule